// File: doc/BRIEF.md
# ALU with Sign-Outcome Classifier

This block is the arithmetic stage of a single-cycle processor datapath. It takes a two-bit operation class from the main instruction decoder together with selected bits of the function field. From these it picks one of five operations: add, subtract, AND, OR and XOR. That operation is applied to two 32-bit operands. Address arithmetic uses the add class, branch comparison uses the subtract class, immediate-OR uses the OR class, and register-register instructions use the function-decode class.

The result then goes to a sign-aware comparator that tests it against zero. The comparator returns a two-bit outcome code, which the datapath writes to the destination register of the modified register-register instructions. The block also produces a zero flag that branch logic uses to test equality. It produces a jump-register indication when a register-register instruction has its top function bit clear. The whole block is combinational, so every output settles in the same cycle as its inputs.

Top module: `alu_classify_unit`

## Requirements
- R1: With class 2'b00, the operation is ADD: result_o = a_i + b_i.
- R2: With class 2'b01, the operation is SUB: result_o = a_i - b_i.
- R3: With class 2'b11, the operation is OR: result_o = a_i | b_i.
- R4: With class 2'b10, fn_low_i selects the operation, whatever the value of fn_top_i:
  - 3'b000 selects ADD.
  - 3'b010 selects SUB.
  - 3'b100 selects AND.
  - 3'b101 selects OR.
  - 3'b110 selects XOR.
- R5: With class 2'b10 and fn_low_i set to 3'b001, 3'b011 or 3'b111, result_o is zero and jr_o is low.
- R6: Add and subtract wrap modulo 2^32, and every later output uses only the 32-bit result.
- R7: outcome_o is 2'd1 when result_o is zero.
- R8: outcome_o is 2'd2 when result_o is negative as a two's-complement value (bit 31 set).
- R9: outcome_o is 2'd3 when result_o is positive as a two's-complement value (nonzero, bit 31 clear).
- R10: zero_o is high exactly when result_o is all zeros.
- R11: jr_o is high when the class is 2'b10, fn_top_i is 0, and fn_low_i is one of the codes that R4 decodes. In every other case jr_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cls_i | input | 2 | Operation class from the main decoder |
| fn_top_i | input | 1 | Function field bit 5 |
| fn_low_i | input | 3 | Function field bits 2..0 |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | ALU result |
| outcome_o | output | 2 | Sign outcome: 1 zero, 2 negative, 3 positive |
| zero_o | output | 1 | Result equals zero |
| jr_o | output | 1 | Jump-register indication |

## Verification
Every output is a combinational function of the current inputs, so each result is due in the same cycle as its stimulus, with no register on the path. The bench changes inputs just after a rising clock edge and samples all four outputs at the following falling edge. This gives the logic half a period to settle, and no check depends on the order in which processes run at an edge. The expected values come from a small reference model in the bench that is built from the requirements.

// File: rtl/alu_cls_pkg.sv
package alu_cls_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    CLS_MEM = 2'b00,
    CLS_BRN = 2'b01,
    CLS_FUN = 2'b10,
    CLS_IMM = 2'b11
  } op_class_e;

  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_NONE = 3'b011,
    OP_ADD  = 3'b100,
    OP_SUB  = 3'b101,
    OP_XOR  = 3'b110
  } alu_op_e;

  typedef enum logic [1:0] {
    OUT_ZERO = 2'd1,
    OUT_NEG  = 2'd2,
    OUT_POS  = 2'd3
  } outcome_e;
endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
  import alu_cls_pkg::*;
(
  input  logic [1:0] cls_i,
  input  logic       fn_top_i,
  input  logic [2:0] fn_low_i,
  output alu_op_e    op_o,
  output logic       jr_o
);
  alu_op_e fn_op;
  logic    fn_known;

  always_comb begin
    fn_known = 1'b1;
    unique case (fn_low_i)
      3'b000:  fn_op = OP_ADD;
      3'b010:  fn_op = OP_SUB;
      3'b100:  fn_op = OP_AND;
      3'b101:  fn_op = OP_OR;
      3'b110:  fn_op = OP_XOR;
      default: begin
        fn_op    = OP_NONE;
        fn_known = 1'b0;
      end
    endcase
  end

  always_comb begin
    unique case (op_class_e'(cls_i))
      CLS_MEM: op_o = OP_ADD;
      CLS_BRN: op_o = OP_SUB;
      CLS_IMM: op_o = OP_OR;
      default: op_o = fn_op;
    endcase
  end

  assign jr_o = (cls_i == CLS_FUN) && !fn_top_i && fn_known;

  always_comb begin
    p_jr_needs_fun_r11: assert (!jr_o || (cls_i == CLS_FUN && !fn_top_i))
      else $error("jr outside function class");
    p_imm_is_or_r3: assert (cls_i != CLS_IMM || op_o == OP_OR)
      else $error("immediate class not OR");
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_cls_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   res_o,
  output logic           zero_o
);
  logic [W-1:0] sum, dif;
  assign sum = a_i + b_i;  // wraps mod 2^W
  assign dif = a_i - b_i;

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = sum;
      OP_SUB:  res_o = dif;
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end

  assign zero_o = ~|res_o;

  always_comb begin
    p_none_zero_r5: assert (op_i != OP_NONE || zero_o)
      else $error("unused op gave nonzero result");
  end
endmodule

// File: rtl/sign_classifier.sv
module sign_classifier
  import alu_cls_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] val_i,
  output outcome_e     outcome_o
);
  localparam logic [W-1:0] REF = '0;

  logic sa, sb, gt, lt, eq;
  assign sa = val_i[W-1];
  assign sb = REF[W-1];
  assign eq = (val_i == REF);

  // sign bits decide when they differ, magnitude otherwise
  always_comb begin
    if (sa != sb) begin
      gt = ~sa;
      lt = sa;
    end else begin
      gt = val_i > REF;
      lt = val_i < REF;
    end
  end

  always_comb begin
    if (eq)      outcome_o = OUT_ZERO;
    else if (lt) outcome_o = OUT_NEG;
    else         outcome_o = OUT_POS;
  end

  always_comb begin
    p_code_legal_r7: assert (outcome_o != 2'd0)
      else $error("illegal outcome code");
    p_neg_has_sign_r8: assert (outcome_o != OUT_NEG || val_i[W-1])
      else $error("negative without sign bit");
    p_one_relation_r9: assert ($countones({gt, lt, eq}) == 1)
      else $error("comparator not exclusive");
  end
endmodule

// File: rtl/alu_classify_unit.sv
module alu_classify_unit
  import alu_cls_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [1:0]   cls_i,
  input  logic         fn_top_i,
  input  logic [2:0]   fn_low_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o,
  output logic [1:0]   outcome_o,
  output logic         zero_o,
  output logic         jr_o
);
  alu_op_e  op;
  outcome_e outcome;

  alu_op_decoder u_dec (
    .cls_i   (cls_i),
    .fn_top_i(fn_top_i),
    .fn_low_i(fn_low_i),
    .op_o    (op),
    .jr_o    (jr_o)
  );

  alu_core #(.W(W)) u_alu (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (result_o),
    .zero_o(zero_o)
  );

  sign_classifier #(.W(W)) u_cls (
    .val_i    (result_o),
    .outcome_o(outcome)
  );

  assign outcome_o = outcome;

  always_comb begin
    p_zero_agrees_r10: assert (zero_o == (outcome_o == OUT_ZERO))
      else $error("zero flag disagrees with outcome");
  end
endmodule

// File: tb/alu_classify_unit_tb_top.sv
module alu_classify_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]  cls;
  logic        fn_top;
  logic [2:0]  fn_low;
  logic [31:0] a, b, result;
  logic [1:0]  outcome;
  logic        zero, jr;

  int checks = 0;
  int errors = 0;

  alu_classify_unit dut_i (
    .cls_i(cls), .fn_top_i(fn_top), .fn_low_i(fn_low),
    .a_i(a), .b_i(b), .result_o(result), .outcome_o(outcome),
    .zero_o(zero), .jr_o(jr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] cls_of(input logic [31:0] r);
    if (r == 0) return 2'd1;
    if (r[31])  return 2'd2;
    return 2'd3;
  endfunction

  task automatic apply(input logic [1:0] c, input logic ft, input logic [2:0] fl,
                       input logic [31:0] x, input logic [31:0] y);
    @(posedge clk); #1;
    cls = c; fn_top = ft; fn_low = fl; a = x; b = y;
    @(negedge clk);
  endtask

  task automatic check_all(input string req, input logic [31:0] exp_res,
                           input logic exp_jr);
    chk(req, "result", result, exp_res);
    chk("R7/R8/R9", "outcome", {30'd0, outcome}, {30'd0, cls_of(exp_res)});
    chk("R10", "zero", {31'd0, zero}, {31'd0, exp_res == 0});
    chk("R11", "jr", {31'd0, jr}, {31'd0, exp_jr});
  endtask

  task automatic t_reset;
    apply(2'b00, 1'b0, 3'b000, 32'd0, 32'd0);
    check_all("R1", 32'd0, 1'b0);
    chk("R7", "zero outcome", {30'd0, outcome}, 32'd1);
  endtask

  task automatic t_mem_add;  // R1
    apply(2'b00, 1'b1, 3'b111, 32'd9, 32'd2);
    check_all("R1", 32'd11, 1'b0);
    apply(2'b00, 1'b0, 3'b100, 32'h1234_0000, 32'h0000_5678);
    check_all("R1", 32'h1234_5678, 1'b0);
  endtask

  task automatic t_branch_sub;  // R2
    apply(2'b01, 1'b1, 3'b000, 32'd7, 32'd7);
    check_all("R2", 32'd0, 1'b0);
    apply(2'b01, 1'b1, 3'b000, 32'd5, 32'd8);
    check_all("R2", 32'hFFFF_FFFD, 1'b0);
    chk("R8", "neg outcome", {30'd0, outcome}, 32'd2);
  endtask

  task automatic t_imm_or;  // R3
    apply(2'b11, 1'b1, 3'b010, 32'h0000_0000, 32'h0000_0008);
    check_all("R3", 32'h8, 1'b0);
    chk("R9", "pos outcome", {30'd0, outcome}, 32'd3);
  endtask

  task automatic t_fun_decode;  // R4
    logic [31:0] x = 32'h0000_00F7, y = 32'h0000_001B;
    apply(2'b10, 1'b1, 3'b000, x, y); check_all("R4", x + y, 1'b0);
    apply(2'b10, 1'b1, 3'b010, x, y); check_all("R4", x - y, 1'b0);
    apply(2'b10, 1'b1, 3'b100, x, y); check_all("R4", x & y, 1'b0);
    apply(2'b10, 1'b1, 3'b101, x, y); check_all("R4", x | y, 1'b0);
    apply(2'b10, 1'b1, 3'b110, x, y); check_all("R4", x ^ y, 1'b0);
    apply(2'b10, 1'b1, 3'b110, 32'hA5A5_A5A5, 32'hA5A5_A5A5);
    check_all("R4", 32'd0, 1'b0);
  endtask

  task automatic t_unused;  // R5
    for (int i = 0; i < 3; i++) begin
      logic [2:0] code = (i == 0) ? 3'b001 : (i == 1) ? 3'b011 : 3'b111;
      apply(2'b10, 1'b0, code, 32'hDEAD_BEEF, 32'h1111_2222);
      check_all("R5", 32'd0, 1'b0);
    end
  endtask

  task automatic t_wrap;  // R6
    apply(2'b00, 1'b0, 3'b000, 32'hFFFF_FFFF, 32'd1);
    check_all("R6", 32'd0, 1'b0);
    apply(2'b00, 1'b0, 3'b000, 32'h7FFF_FFFF, 32'd1);
    check_all("R6", 32'h8000_0000, 1'b0);
    chk("R8", "overflowed sum negative", {30'd0, outcome}, 32'd2);
    apply(2'b01, 1'b0, 3'b000, 32'h8000_0000, 32'd1);
    check_all("R6", 32'h7FFF_FFFF, 1'b0);
    chk("R9", "wrapped diff positive", {30'd0, outcome}, 32'd3);
  endtask

  task automatic t_jr;  // R11
    apply(2'b10, 1'b0, 3'b000, 32'd40, 32'd0);
    check_all("R11", 32'd40, 1'b1);
    apply(2'b10, 1'b0, 3'b110, 32'd3, 32'd1);
    check_all("R11", 32'd2, 1'b1);
    apply(2'b01, 1'b0, 3'b000, 32'd3, 32'd1);
    check_all("R11", 32'd2, 1'b0);
  endtask

  initial begin
    cls = '0; fn_top = 1'b0; fn_low = '0; a = '0; b = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_mem_add();
    t_branch_sub();
    t_imm_or();
    t_fun_decode();
    t_unused();
    t_wrap();
    t_jr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule